// File: doc/BRIEF.md
# Bit-Oriented Code Word Detector

This block watches the serial bit stream of an extended-superframe data link, which arrives one bit per enabled clock, for repeated 16-bit bit-oriented code words. Each word is a zero, six code bits, a zero, and then eight ones, sent in that order. The block finds the word boundary on its own by searching the stream for that shape. Once aligned, it checks each following 16-bit slot. When the same 6-bit code has arrived a programmable number of times in a row, the block stores the code in an 8-bit result register and raises a sticky detect flag. Software clears the flag with a one-cycle write strobe.

The control is a three-state machine. ST_HUNT checks every incoming bit for a complete code word. When it finds one, it moves to ST_LOCK with a count of 1, or straight to ST_DONE with a detection if the threshold is 1. ST_LOCK counts 16 bits and checks the slot at the boundary. The same code adds one to the count and moves to ST_DONE with a detection once the count reaches the threshold. A different code starts the count again at 1. A slot that is not a code word sends the machine back to ST_HUNT. ST_DONE holds after a detection. Further words with the same code keep it in ST_DONE. A different code restarts counting, as it would from ST_HUNT. A slot that is not a code word returns the machine to ST_HUNT, which re-arms it. HDLC traffic never matches and is ignored.

Top module: `bom_detector`

## Requirements
- R1: After reset, `code_out` is 8'h00 and `det_flag` is 0.
- R2: A code word is 16 bits, received first bit first: 0, c5, c4, c3, c2, c1, c0, 0, then eight 1s. On detection `code_out` becomes {2'b00, c5..c0}.
- R3: Detection happens on the bit that completes the N-th consecutive aligned word carrying the same code, where N is the effective threshold. It does not happen after N-1 such words.
- R4: An aligned code word whose code differs from the previous word restarts the count at 1.
- R5: A `rep_thresh` value of 0 acts as 1, and values 11 to 15 act as 10. Values 1 to 10 are used as given.
- R6: `det_flag` stays set until `clr_det` is high for a cycle. If a detection and `clr_det` happen in the same cycle, the flag ends up set.
- R7: `code_out` changes only on a detection. It keeps the last detected code across flag clears and non-matching traffic.
- R8: After a detection, further words with the same code do not raise another detection. Detection re-arms only after a 16-bit slot that is not a code word.
- R9: A bit is taken only in cycles where `bit_en` is 1. `bit_in` is ignored in all other cycles.
- R10: Word alignment is found by searching at any bit offset. Streams without eight consecutive 1s after a 0xxxxxx0 byte, such as HDLC flags 0x7E and data, never cause a detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Serial data link bit |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| rep_thresh | input | 4 | Required consecutive receptions |
| clr_det | input | 1 | One-cycle strobe that clears `det_flag` |
| code_out | output | 8 | Last detected code, zero-extended |
| det_flag | output | 1 | Sticky detection status |

## Verification
The tests use runs of one code that are exactly one word short of the threshold and then exactly at it. This separates counting to N from counting to N-1. A run interrupted by a different code shows whether the count restarts or carries on. Long runs that continue past a detection, and that run followed by an idle slot and a fresh run, show the difference between staying in ST_DONE and re-arming. Words spread out with idle cycles carrying junk bits, HDLC flag streams, and words starting at offsets that are not multiples of 16 test the enable qualification and the alignment search separately.

// File: rtl/bom_pkg.sv
package bom_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOCK = 2'd1,
        ST_DONE = 2'd2
    } bom_state_e;

endpackage

// File: rtl/bom_shift.sv
module bom_shift #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_en,
    output logic              word_hit,
    output logic [CODE_W-1:0] word_code
);

    localparam int HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_nxt;

    assign sr_nxt = {sr_q[WORD_W-2:0], bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (bit_en) begin
            sr_q <= sr_nxt;
        end
    end

    // Shape check on the window that includes the current bit
    assign word_hit  = (sr_nxt[HALF_W-1:0] == {HALF_W{1'b1}}) &&
                       !sr_nxt[HALF_W] && !sr_nxt[WORD_W-1];
    assign word_code = sr_nxt[WORD_W-2 -: CODE_W];

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(sr_q)); // R9

endmodule

// File: rtl/bom_thresh.sv
module bom_thresh #(
    parameter int THR_W   = 4,
    parameter int MAX_REP = 10
) (
    input  logic [THR_W-1:0] thr_raw,
    output logic [THR_W-1:0] thr_eff
);

    localparam logic [THR_W-1:0] MAX_V = THR_W'(MAX_REP);
    localparam logic [THR_W-1:0] ONE_V = THR_W'(1);

    always_comb begin
        if (thr_raw == '0) begin
            thr_eff = ONE_V;
        end else if (thr_raw > MAX_V) begin
            thr_eff = MAX_V;
        end else begin
            thr_eff = thr_raw;
        end
    end

    always_comb begin
        assert (thr_eff != '0 && thr_eff <= MAX_V); // R5
    end

endmodule

// File: rtl/bom_ctrl.sv
module bom_ctrl
    import bom_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int CODE_W  = 6,
    parameter int THR_W   = 4,
    parameter int MAX_REP = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              word_hit,
    input  logic [CODE_W-1:0] word_code,
    input  logic [THR_W-1:0]  thr_eff,
    output logic              det_pulse,
    output logic [CODE_W-1:0] det_code
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
    localparam logic [THR_W-1:0] ONE_V    = THR_W'(1);

    bom_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
    logic [THR_W-1:0]  rep_q, rep_d;
    logic [CODE_W-1:0] last_q, last_d;
    logic              det_d;
    logic              same_code;

    assign same_code = (word_code == last_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            bitcnt_q <= '0;
            rep_q    <= '0;
            last_q   <= '0;
        end else begin
            state_q  <= state_d;
            bitcnt_q <= bitcnt_d;
            rep_q    <= rep_d;
            last_q   <= last_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        bitcnt_d = bitcnt_q;
        rep_d    = rep_q;
        last_d   = last_q;
        det_d    = 1'b0;
        if (bit_en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (word_hit) begin
                        rep_d    = ONE_V;
                        last_d   = word_code;
                        bitcnt_d = '0;
                        if (thr_eff == ONE_V) begin
                            det_d   = 1'b1;
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_LOCK;
                        end
                    end
                end
                ST_LOCK, ST_DONE: begin
                    bitcnt_d = bitcnt_q + 1'b1;
                    if (bitcnt_q == LAST_BIT) begin
                        if (!word_hit) begin
                            state_d = ST_HUNT;
                            rep_d   = '0;
                        end else if (same_code && state_q == ST_DONE) begin
                            state_d = ST_DONE;
                        end else if (same_code) begin
                            rep_d = rep_q + 1'b1;
                            if (rep_q + 1'b1 >= thr_eff) begin
                                det_d   = 1'b1;
                                state_d = ST_DONE;
                            end
                        end else begin
                            rep_d  = ONE_V;
                            last_d = word_code;
                            if (thr_eff == ONE_V) begin
                                det_d   = 1'b1;
                                state_d = ST_DONE;
                            end else begin
                                state_d = ST_LOCK;
                            end
                        end
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        det_pulse = det_d;
        det_code  = word_code;
    end

    AST_REP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= THR_W'(MAX_REP)); // R3
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (det_pulse && state_q == ST_DONE) |-> (word_code != last_q)); // R8
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(state_q) && $stable(rep_q))); // R9
    AST_DET_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> (bit_en && word_hit)); // R10

endmodule

// File: rtl/bom_result.sv
module bom_result #(
    parameter int CODE_W = 6,
    parameter int OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_pulse,
    input  logic [CODE_W-1:0] det_code,
    input  logic              clr_det,
    output logic [OUT_W-1:0]  code_q,
    output logic              flag_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (det_pulse) begin
                code_q <= OUT_W'(det_code);
            end
            if (det_pulse) begin
                flag_q <= 1'b1;
            end else if (clr_det) begin
                flag_q <= 1'b0;
            end
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_det) |=> flag_q); // R6
    AST_CODE_ONLY_ON_DET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> flag_q); // R7

endmodule

// File: rtl/bom_detector.sv
module bom_detector #(
    parameter int WORD_W  = 16,
    parameter int CODE_W  = 6,
    parameter int THR_W   = 4,
    parameter int MAX_REP = 10,
    parameter int OUT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_en,
    input  logic [THR_W-1:0] rep_thresh,
    input  logic             clr_det,
    output logic [OUT_W-1:0] code_out,
    output logic             det_flag
);

    logic              word_hit;
    logic [CODE_W-1:0] word_code;
    logic [THR_W-1:0]  thr_eff;
    logic              det_pulse;
    logic [CODE_W-1:0] det_code;

    bom_shift #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_en    (bit_en),
        .word_hit  (word_hit),
        .word_code (word_code)
    );

    bom_thresh #(.THR_W(THR_W), .MAX_REP(MAX_REP)) u_thresh (
        .thr_raw (rep_thresh),
        .thr_eff (thr_eff)
    );

    bom_ctrl #(
        .WORD_W(WORD_W), .CODE_W(CODE_W), .THR_W(THR_W), .MAX_REP(MAX_REP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .word_hit  (word_hit),
        .word_code (word_code),
        .thr_eff   (thr_eff),
        .det_pulse (det_pulse),
        .det_code  (det_code)
    );

    bom_result #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .det_pulse (det_pulse),
        .det_code  (det_code),
        .clr_det   (clr_det),
        .code_q    (code_out),
        .flag_q    (det_flag)
    );

endmodule

// File: tb/bom_detector_bench.sv
module bom_detector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_en = 1'b0;
    logic [3:0] rep_thresh = 4'd3;
    logic       clr_det = 1'b0;
    logic [7:0] code_out;
    logic       det_flag;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bom_detector u_bom_detector (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_en     (bit_en),
        .rep_thresh (rep_thresh),
        .clr_det    (clr_det),
        .code_out   (code_out),
        .det_flag   (det_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic clr = 1'b0);
        @(negedge clk);
        bit_in  = b;
        bit_en  = 1'b1;
        clr_det = clr;
        @(negedge clk);
        bit_en  = 1'b0;
        clr_det = 1'b0;
    endtask

    task automatic send_word(input logic [5:0] c, input int gap = 0, input logic clr_last = 1'b0);
        logic [15:0] w;
        w = {1'b0, c, 1'b0, 8'hFF};
        for (int i = 15; i >= 0; i--) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_in = ~w[i];
            end
            send_bit(w[i], (i == 0) ? clr_last : 1'b0);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic flush(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_det = 1'b1;
        @(negedge clk);
        clr_det = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 code", int'(code_out), 0);
        check("R1 flag", int'(det_flag), 0);
    endtask

    task automatic t_basic();
        rep_thresh = 4'd3;
        flush(21);
        send_word(6'h2D);
        send_word(6'h2D);
        check("R3 below threshold", int'(det_flag), 0);
        send_word(6'h2D);
        check("R3 at threshold", int'(det_flag), 1);
        check("R2 code value", int'(code_out), 8'h2D);
    endtask

    task automatic t_clear();
        pulse_clear();
        check("R6 cleared", int'(det_flag), 0);
        check("R7 code kept", int'(code_out), 8'h2D);
    endtask

    task automatic t_no_retrigger();
        for (int i = 0; i < 4; i++) send_word(6'h2D);
        check("R8 same run", int'(det_flag), 0);
        flush(16);
        check("R7 code kept idle", int'(code_out), 8'h2D);
        for (int i = 0; i < 3; i++) send_word(6'h2D);
        check("R8 rearmed", int'(det_flag), 1);
        pulse_clear();
    endtask

    task automatic t_restart();
        rep_thresh = 4'd3;
        flush(19);
        send_word(6'h11);
        send_word(6'h11);
        send_word(6'h0A);
        send_word(6'h0A);
        check("R4 restarted count", int'(det_flag), 0);
        check("R7 old code held", int'(code_out), 8'h2D);
        send_word(6'h0A);
        check("R4 new run detect", int'(det_flag), 1);
        check("R4 new code", int'(code_out), 8'h0A);
        pulse_clear();
    endtask

    task automatic t_set_wins();
        rep_thresh = 4'd1;
        flush(17);
        send_word(6'h33, 0, 1'b1);
        check("R6 set beats clear", int'(det_flag), 1);
        check("R2 code thr1", int'(code_out), 8'h33);
        pulse_clear();
    endtask

    task automatic t_clamp();
        rep_thresh = 4'd0;
        flush(18);
        send_word(6'h01);
        check("R5 zero acts as one", int'(det_flag), 1);
        pulse_clear();
        rep_thresh = 4'd15;
        flush(16);
        for (int i = 0; i < 9; i++) send_word(6'h3E);
        check("R5 fifteen not at nine", int'(det_flag), 0);
        send_word(6'h3E);
        check("R5 fifteen acts as ten", int'(det_flag), 1);
        check("R5 code", int'(code_out), 8'h3E);
        pulse_clear();
        rep_thresh = 4'd10;
        flush(16);
        for (int i = 0; i < 9; i++) send_word(6'h15);
        check("R3 ten not at nine", int'(det_flag), 0);
        send_word(6'h15);
        check("R3 ten detect", int'(det_flag), 1);
        pulse_clear();
    endtask

    task automatic t_gaps();
        rep_thresh = 4'd2;
        flush(16);
        send_word(6'h27, 3);
        check("R9 one gapped word", int'(det_flag), 0);
        send_word(6'h27, 2);
        check("R9 gapped detect", int'(det_flag), 1);
        check("R9 gapped code", int'(code_out), 8'h27);
        pulse_clear();
        // junk while disabled must not reach the shifter
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            bit_in = (i % 3) != 0;
        end
        rep_thresh = 4'd1;
        flush(16);
        check("R9 junk ignored", int'(det_flag), 0);
    endtask

    task automatic t_hdlc();
        rep_thresh = 4'd1;
        flush(16);
        for (int i = 0; i < 20; i++) send_byte(8'h7E);
        send_byte(8'h3C);
        send_byte(8'hFE);
        send_byte(8'h7E);
        check("R10 hdlc ignored", int'(det_flag), 0);
        flush(5);
        send_word(6'h09);
        check("R10 odd offset align", int'(det_flag), 1);
        check("R10 code", int'(code_out), 8'h09);
        pulse_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_no_retrigger();
        t_restart();
        t_set_wins();
        t_clamp();
        t_gaps();
        t_hdlc();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule